// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Occupancy Flags

This block is a first-in first-out buffer for 9-bit words that crosses between two unrelated clocks. Words enter on the rising edge of the write clock and leave through a registered output on the rising edge of the read clock. Four active-low status flags report how full the buffer is: empty and almost-empty belong to the read clock, and full and almost-full belong to the write clock. The almost-empty threshold `n` and the almost-full threshold `m` are programmable.

Two clock-domain state machines drive the flags. The write side has the states `W_ROOM`, `W_NEAR` and `W_FULL`. The read side has the states `R_EMPTY`, `R_SPARSE` and `R_AVAIL`. At every edge of its own clock, each machine re-enters the state that matches the occupancy it will have after that edge's operation, so any state can reach any other. The write-side transitions are:

- ROOM to NEAR: the count reaches depth−m.
- NEAR to FULL: the count reaches depth.
- FULL back to NEAR or ROOM: reads seen by the write side lower the count.

The read side works the same way, with EMPTY to SPARSE at the first word and SPARSE to AVAIL above n.

A dual-purpose pin, `wr_en2_ld`, is sampled while reset is held, once in each clock domain. The result is the pin role, with two values:

- **`PIN_WEN2`**: the pin is a second write enable, and the thresholds are fixed at 7.
- **`PIN_LOAD`**: the pin is the access control of a separate offset register file. That file supplies `empty_ofs` and `full_ofs`. While the pin is low, FIFO reads and writes are suspended so the offset file can use the ports.

The output bus is modelled as `rd_data` plus a drive-enable, `rd_data_drv`.

Top module: `dualclk_flag_fifo`

## Requirements
- R1: While `rst_n` is low, both pointers return to the first location. `full_n` and `afull_n` read 1, `empty_n` and `aempty_n` read 0, and `rd_data` is cleared to 0. This holds also when reset is applied with words stored.
- R2: Once the flags have settled, with c words held, the flags are as follows. `empty_n` is 0 exactly when c = 0. `aempty_n` is 0 exactly when c ≤ n. `afull_n` is 0 exactly when c ≥ DEPTH−m. `full_n` is 0 exactly when c = DEPTH. A low `full_n` implies a low `afull_n`, and a low `empty_n` implies a low `aempty_n`. This holds for n and m anywhere from 0 to DEPTH−1.
- R3: If `wr_en2_ld` is 1 during reset, `load_mode` reads 0 and n = m = 7 regardless of `empty_ofs` and `full_ofs`. If `wr_en2_ld` is 0 during reset, `load_mode` reads 1 and n and m follow those inputs. `load_mode` does not change outside reset.
- R4: In both modes, a word is stored at a write-clock edge only when `wr_en1_n` is 0 and `wr_en2_ld` is 1.
- R5: A word is read at a read-clock edge only when `rd_en1_n` and `rd_en2_n` are both 0. In load mode, `wr_en2_ld` must also be 1, while in the other mode `wr_en2_ld` does not gate reads. Otherwise `rd_data` holds its value.
- R6: A write attempted while `full_n` is 0 changes nothing, and a read attempted while `empty_n` is 0 leaves `rd_data` unchanged.
- R7: Words leave in the order they were written, and the word read appears on `rd_data` after that read edge.
- R8: `rd_data_drv` is 1 when `out_en_n` is 0, and 0 when `out_en_n` is 1.
- R9: `full_n`, `afull_n`, `empty_n` and `aempty_n` each change only on their own clock. A flag set by its own side's operation changes at that same edge. A change caused by the other side reaches the flag at the third edge of the flag's clock after the operation, when the two clocks are equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| rst_n | input | 1 | Active-low reset for both domains |
| wr_data | input | 9 | Word to write |
| wr_en1_n | input | 1 | Primary write enable, active low |
| wr_en2_ld | input | 1 | Second write enable or offset access control; level sampled in reset picks the role |
| rd_en1_n | input | 1 | Read enable one, active low |
| rd_en2_n | input | 1 | Read enable two, active low |
| out_en_n | input | 1 | Output drive enable, active low |
| empty_ofs | input | log2(DEPTH) | Almost-empty threshold n from the offset file |
| full_ofs | input | log2(DEPTH) | Almost-full threshold m from the offset file |
| load_mode | output | 1 | 1 when the dual-purpose pin acts as offset access control |
| rd_data | output | 9 | Registered output word |
| rd_data_drv | output | 1 | 1 when the output bus is driven |
| empty_n | output | 1 | Empty flag, active low, read clock |
| aempty_n | output | 1 | Almost-empty flag, active low, read clock |
| afull_n | output | 1 | Almost-full flag, active low, write clock |
| full_n | output | 1 | Full flag, active low, write clock |

## Verification
Each result has a fixed due time:

- **Own side**: `rd_data` and the flags that the operating side owns are due at the edge of the operation itself. The bench therefore samples them at the falling edge right after.
- **Other side**: a change the opposite side causes passes two synchronizer flops and then the state register. It is therefore due at the third edge, and the bench checks it both before that edge (still old) and after it.

Every occupancy sweep waits five idle edges after each operation, which is beyond that three-edge window, before comparing all four flags against the word-count table.

// File: rtl/fifo_dc_pkg.sv
package fifo_dc_pkg;
    localparam int WORD_W      = 9;
    localparam int OFS_DEFAULT = 7;

    typedef enum logic [1:0] {
        W_ROOM = 2'd0,
        W_NEAR = 2'd1,
        W_FULL = 2'd2
    } wr_zone_e;

    typedef enum logic [1:0] {
        R_EMPTY  = 2'd0,
        R_SPARSE = 2'd1,
        R_AVAIL  = 2'd2
    } rd_zone_e;

    typedef enum logic {
        PIN_WEN2 = 1'b0,
        PIN_LOAD = 1'b1
    } pin_role_e;
endpackage

// File: rtl/fifo_dc_sync.sv
module fifo_dc_sync #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/fifo_dc_mem.sv
module fifo_dc_mem #(
    parameter int DEPTH = 64,
    parameter int DW    = 9,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          wr_clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_word,
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_word
);
    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (wr_en) begin
            cells[wr_addr] <= wr_word;
        end
    end

    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_word <= '0;
        end else if (rd_en) begin
            rd_word <= cells[rd_addr];
        end
    end
endmodule

// File: rtl/fifo_dc_wr_side.sv
module fifo_dc_wr_side
    import fifo_dc_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          wr_clk,
    input  logic          rst_n,
    input  logic          wr_req,
    input  logic [AW-1:0] full_ofs,
    input  logic [AW:0]   rd_gray_s,
    output logic          wr_fire,
    output logic [AW-1:0] wr_addr,
    output logic [AW:0]   wr_gray,
    output logic          full_n,
    output logic          afull_n
);
    localparam logic [AW:0] CAP = (AW+1)'(DEPTH);

    wr_zone_e    zone, zone_nxt;
    logic [AW:0] wr_bin, wr_bin_nxt, rd_bin_s, used_nxt, near_mark;

    always_comb begin
        for (int i = 0; i <= AW; i++) begin
            rd_bin_s[i] = ^(rd_gray_s >> i);
        end
    end

    assign wr_fire    = wr_req && (zone != W_FULL);
    assign wr_bin_nxt = wr_bin + {{AW{1'b0}}, wr_fire};
    assign used_nxt   = wr_bin_nxt - rd_bin_s;
    assign near_mark  = CAP - {1'b0, full_ofs};
    assign wr_addr    = wr_bin[AW-1:0];

    always_comb begin
        if (used_nxt == CAP) begin
            zone_nxt = W_FULL;
        end else if (used_nxt >= near_mark) begin
            zone_nxt = W_NEAR;
        end else begin
            zone_nxt = W_ROOM;
        end
    end

    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) begin
            zone <= W_ROOM;
        end else begin
            zone <= zone_nxt;
        end
    end

    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_bin  <= '0;
            wr_gray <= '0;
        end else begin
            wr_bin  <= wr_bin_nxt;
            wr_gray <= wr_bin_nxt ^ (wr_bin_nxt >> 1);
        end
    end

    always_comb begin
        unique case (zone)
            W_ROOM:  begin full_n = 1'b1; afull_n = 1'b1; end
            W_NEAR:  begin full_n = 1'b1; afull_n = 1'b0; end
            W_FULL:  begin full_n = 1'b0; afull_n = 1'b0; end
            default: begin full_n = 1'b1; afull_n = 1'b1; end
        endcase
    end
endmodule

// File: rtl/fifo_dc_rd_side.sv
module fifo_dc_rd_side
    import fifo_dc_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic          rd_req,
    input  logic [AW-1:0] empty_ofs,
    input  logic [AW:0]   wr_gray_s,
    output logic          rd_fire,
    output logic [AW-1:0] rd_addr,
    output logic [AW:0]   rd_gray,
    output logic          empty_n,
    output logic          aempty_n
);
    rd_zone_e    zone, zone_nxt;
    logic [AW:0] rd_bin, rd_bin_nxt, wr_bin_s, used_nxt;

    always_comb begin
        for (int i = 0; i <= AW; i++) begin
            wr_bin_s[i] = ^(wr_gray_s >> i);
        end
    end

    assign rd_fire    = rd_req && (zone != R_EMPTY);
    assign rd_bin_nxt = rd_bin + {{AW{1'b0}}, rd_fire};
    assign used_nxt   = wr_bin_s - rd_bin_nxt;
    assign rd_addr    = rd_bin[AW-1:0];

    always_comb begin
        if (used_nxt == '0) begin
            zone_nxt = R_EMPTY;
        end else if (used_nxt <= {1'b0, empty_ofs}) begin
            zone_nxt = R_SPARSE;
        end else begin
            zone_nxt = R_AVAIL;
        end
    end

    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) begin
            zone <= R_EMPTY;
        end else begin
            zone <= zone_nxt;
        end
    end

    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_bin  <= '0;
            rd_gray <= '0;
        end else begin
            rd_bin  <= rd_bin_nxt;
            rd_gray <= rd_bin_nxt ^ (rd_bin_nxt >> 1);
        end
    end

    always_comb begin
        unique case (zone)
            R_EMPTY:  begin empty_n = 1'b0; aempty_n = 1'b0; end
            R_SPARSE: begin empty_n = 1'b1; aempty_n = 1'b0; end
            R_AVAIL:  begin empty_n = 1'b1; aempty_n = 1'b1; end
            default:  begin empty_n = 1'b0; aempty_n = 1'b0; end
        endcase
    end
endmodule

// File: rtl/dualclk_flag_fifo.sv
module dualclk_flag_fifo
    import fifo_dc_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic                     wr_clk,
    input  logic                     rd_clk,
    input  logic                     rst_n,
    input  logic [WORD_W-1:0]        wr_data,
    input  logic                     wr_en1_n,
    input  logic                     wr_en2_ld,
    input  logic                     rd_en1_n,
    input  logic                     rd_en2_n,
    input  logic                     out_en_n,
    input  logic [$clog2(DEPTH)-1:0] empty_ofs,
    input  logic [$clog2(DEPTH)-1:0] full_ofs,
    output logic                     load_mode,
    output logic [WORD_W-1:0]        rd_data,
    output logic                     rd_data_drv,
    output logic                     empty_n,
    output logic                     aempty_n,
    output logic                     afull_n,
    output logic                     full_n
);
    localparam int            AW      = $clog2(DEPTH);
    localparam logic [AW-1:0] OFS_DEF = AW'(OFS_DEFAULT);

    pin_role_e     wr_role, rd_role;
    logic          wr_req, rd_req, wr_fire, rd_fire;
    logic [AW-1:0] wr_addr, rd_addr, full_ofs_eff, empty_ofs_eff;
    logic [AW:0]   wr_gray, rd_gray, wr_gray_s, rd_gray_s;

    always_ff @(posedge wr_clk) begin
        if (!rst_n) begin
            wr_role <= wr_en2_ld ? PIN_WEN2 : PIN_LOAD;
        end
    end

    always_ff @(posedge rd_clk) begin
        if (!rst_n) begin
            rd_role <= wr_en2_ld ? PIN_WEN2 : PIN_LOAD;
        end
    end

    assign load_mode     = (wr_role == PIN_LOAD);
    assign full_ofs_eff  = (wr_role == PIN_LOAD) ? full_ofs  : OFS_DEF;
    assign empty_ofs_eff = (rd_role == PIN_LOAD) ? empty_ofs : OFS_DEF;
    assign wr_req        = !wr_en1_n && wr_en2_ld;
    assign rd_req        = !rd_en1_n && !rd_en2_n && ((rd_role == PIN_WEN2) || wr_en2_ld);
    assign rd_data_drv   = !out_en_n;

    fifo_dc_wr_side #(.DEPTH(DEPTH), .AW(AW)) u_wr (
        .wr_clk    (wr_clk),
        .rst_n     (rst_n),
        .wr_req    (wr_req),
        .full_ofs  (full_ofs_eff),
        .rd_gray_s (rd_gray_s),
        .wr_fire   (wr_fire),
        .wr_addr   (wr_addr),
        .wr_gray   (wr_gray),
        .full_n    (full_n),
        .afull_n   (afull_n)
    );

    fifo_dc_rd_side #(.DEPTH(DEPTH), .AW(AW)) u_rd (
        .rd_clk    (rd_clk),
        .rst_n     (rst_n),
        .rd_req    (rd_req),
        .empty_ofs (empty_ofs_eff),
        .wr_gray_s (wr_gray_s),
        .rd_fire   (rd_fire),
        .rd_addr   (rd_addr),
        .rd_gray   (rd_gray),
        .empty_n   (empty_n),
        .aempty_n  (aempty_n)
    );

    fifo_dc_sync #(.W(AW+1)) u_w2r (
        .clk   (rd_clk),
        .rst_n (rst_n),
        .d     (wr_gray),
        .q     (wr_gray_s)
    );

    fifo_dc_sync #(.W(AW+1)) u_r2w (
        .clk   (wr_clk),
        .rst_n (rst_n),
        .d     (rd_gray),
        .q     (rd_gray_s)
    );

    fifo_dc_mem #(.DEPTH(DEPTH), .DW(WORD_W), .AW(AW)) u_mem (
        .wr_clk  (wr_clk),
        .wr_en   (wr_fire),
        .wr_addr (wr_addr),
        .wr_word (wr_data),
        .rd_clk  (rd_clk),
        .rst_n   (rst_n),
        .rd_en   (rd_fire),
        .rd_addr (rd_addr),
        .rd_word (rd_data)
    );
endmodule

// File: rtl/dualclk_flag_fifo_chk.sv
module dualclk_flag_fifo_chk
    import fifo_dc_pkg::*;
#(
    parameter int PW = 7
) (
    input logic              wr_clk,
    input logic              rd_clk,
    input logic              rst_n,
    input logic              wr_en1_n,
    input logic              wr_en2_ld,
    input logic              rd_en1_n,
    input logic              rd_en2_n,
    input logic              load_mode,
    input logic [WORD_W-1:0] rd_data,
    input logic              empty_n,
    input logic              aempty_n,
    input logic              afull_n,
    input logic              full_n,
    input logic [PW-1:0]     wr_gray
);
    AST_FULL_IMPLIES_AFULL: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !full_n |-> !afull_n); // R2

    AST_EMPTY_IMPLIES_AEMPTY: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !empty_n |-> !aempty_n); // R2

    AST_NO_WRITE_WHEN_FULL: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (!full_n && !wr_en1_n && wr_en2_ld) |=> $stable(wr_gray)); // R6

    AST_NO_READ_WHEN_EMPTY: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (!empty_n && !rd_en1_n && !rd_en2_n) |=> $stable(rd_data)); // R6

    AST_HOLD_WITHOUT_ENABLES: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (rd_en1_n || rd_en2_n) |=> $stable(rd_data)); // R5

    AST_NO_WRITE_PIN_LOW: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (!wr_en2_ld || wr_en1_n) |=> $stable(wr_gray)); // R4

    AST_ROLE_HELD: assert property (@(posedge wr_clk) disable iff (!rst_n)
        rst_n |=> $stable(load_mode)); // R3
endmodule

bind dualclk_flag_fifo dualclk_flag_fifo_chk #(.PW($clog2(DEPTH) + 1)) u_chk (
    .wr_clk    (wr_clk),
    .rd_clk    (rd_clk),
    .rst_n     (rst_n),
    .wr_en1_n  (wr_en1_n),
    .wr_en2_ld (wr_en2_ld),
    .rd_en1_n  (rd_en1_n),
    .rd_en2_n  (rd_en2_n),
    .load_mode (load_mode),
    .rd_data   (rd_data),
    .empty_n   (empty_n),
    .aempty_n  (aempty_n),
    .afull_n   (afull_n),
    .full_n    (full_n),
    .wr_gray   (wr_gray)
);

// File: tb/dualclk_flag_fifo_test.sv
module dualclk_flag_fifo_test;
    localparam int DEPTH = 64;
    localparam int AW    = 6;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n, wr_en1_n, wr_en2_ld, rd_en1_n, rd_en2_n, out_en_n;
    logic [8:0]    wr_data, rd_data, last_out;
    logic [AW-1:0] empty_ofs, full_ofs;
    logic          load_mode, rd_data_drv, empty_n, aempty_n, afull_n, full_n;
    logic [8:0]    val;

    int checks = 0;
    int errors = 0;
    int n_cur  = 7;
    int m_cur  = 7;
    int model[$];

    dualclk_flag_fifo #(.DEPTH(DEPTH)) uut (
        .wr_clk      (clk),
        .rd_clk      (clk),
        .rst_n       (rst_n),
        .wr_data     (wr_data),
        .wr_en1_n    (wr_en1_n),
        .wr_en2_ld   (wr_en2_ld),
        .rd_en1_n    (rd_en1_n),
        .rd_en2_n    (rd_en2_n),
        .out_en_n    (out_en_n),
        .empty_ofs   (empty_ofs),
        .full_ofs    (full_ofs),
        .load_mode   (load_mode),
        .rd_data     (rd_data),
        .rd_data_drv (rd_data_drv),
        .empty_n     (empty_n),
        .aempty_n    (aempty_n),
        .afull_n     (afull_n),
        .full_n      (full_n)
    );

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic expect_flags(input string tag);
        int c;
        logic [3:0] exp_f, got_f;
        c     = model.size();
        exp_f = {c != DEPTH, c < DEPTH - m_cur, c > n_cur, c != 0};
        got_f = {full_n, afull_n, aempty_n, empty_n};
        check($sformatf("%s words=%0d {full,afull,aempty,empty}", tag, c), got_f, exp_f);
    endtask

    task automatic idle(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic push(input logic [8:0] d);
        @(negedge clk);
        wr_data  = d;
        wr_en1_n = 1'b0;
        @(negedge clk);
        wr_en1_n = 1'b1;
    endtask

    task automatic pop(input string tag);
        @(negedge clk);
        rd_en1_n = 1'b0;
        rd_en2_n = 1'b0;
        @(negedge clk);
        rd_en1_n = 1'b1;
        rd_en2_n = 1'b1;
        if (model.size() > 0) last_out = 9'(model.pop_front());
        check(tag, rd_data, last_out);
    endtask

    task automatic do_reset(input logic pin);
        @(negedge clk);
        rst_n     = 1'b0;
        wr_en2_ld = pin;
        wr_en1_n  = 1'b1;
        rd_en1_n  = 1'b1;
        rd_en2_n  = 1'b1;
        idle(3);
        rst_n     = 1'b1;
        wr_en2_ld = 1'b1;
        model.delete();
        last_out  = '0;
        n_cur     = pin ? 7 : int'(empty_ofs);
        m_cur     = pin ? 7 : int'(full_ofs);
        idle(1);
    endtask

    task automatic sweep(input string tag);
        for (int k = 1; k <= DEPTH; k++) begin
            val = 9'(k * 37 + 5);
            push(val);
            model.push_back(int'(val));
            if (k == DEPTH) check("R9 full_n low at the filling write edge", full_n, 0);
            idle(5);
            expect_flags({"R2 fill ", tag});
        end
        for (int k = 0; k < DEPTH; k++) begin
            pop("R7 output order");
            idle(5);
            expect_flags({"R2 drain ", tag});
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R1..R9 run: got hung expected finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; wr_en1_n = 1'b1; wr_en2_ld = 1'b0; rd_en1_n = 1'b1; rd_en2_n = 1'b1;
        out_en_n = 1'b0; wr_data = '0; empty_ofs = 6'd3; full_ofs = 6'd5; last_out = '0;

        // load mode, n=3 m=5
        do_reset(1'b0);
        check("R3 load_mode after low pin in reset", load_mode, 1);
        expect_flags("R1 reset flags");
        check("R1 rd_data cleared by reset", rd_data, 0);
        check("R8 drive on with out_en_n low", rd_data_drv, 1);
        out_en_n = 1'b1; #1;
        check("R8 drive off with out_en_n high", rd_data_drv, 0);
        out_en_n = 1'b0; #1;

        // cross-domain latency of empty release
        push(9'h155);
        model.push_back(9'h155);
        check("R9 empty_n low after write edge", empty_n, 0);
        idle(2);
        check("R9 empty_n low before third read edge", empty_n, 0);
        idle(1);
        check("R9 empty_n high at third read edge", empty_n, 1);
        pop("R7 single word");
        idle(5);
        expect_flags("R2 drained single");

        sweep("n=3 m=5");

        // read at empty
        pop("R6 read at empty holds rd_data");
        idle(5);
        expect_flags("R6 read at empty");

        // full write ignored
        for (int k = 0; k < DEPTH; k++) begin
            val = 9'(k * 11 + 1);
            push(val);
            model.push_back(int'(val));
        end
        idle(5);
        push(9'h0AA);
        idle(5);
        expect_flags("R6 write at full ignored");
        for (int k = 0; k < DEPTH; k++) pop("R6 R7 contents intact after full write");
        idle(5);
        expect_flags("R6 empty after draining");

        // read enables and pin gating in load mode
        push(9'h1C3); model.push_back(9'h1C3);
        push(9'h03C); model.push_back(9'h03C);
        idle(5);
        @(negedge clk); rd_en1_n = 1'b0;
        @(negedge clk); rd_en1_n = 1'b1;
        check("R5 rd_en2_n high holds rd_data", rd_data, last_out);
        @(negedge clk); rd_en2_n = 1'b0;
        @(negedge clk); rd_en2_n = 1'b1;
        check("R5 rd_en1_n high holds rd_data", rd_data, last_out);
        @(negedge clk); wr_en2_ld = 1'b0; rd_en1_n = 1'b0; rd_en2_n = 1'b0;
        @(negedge clk); wr_en2_ld = 1'b1; rd_en1_n = 1'b1; rd_en2_n = 1'b1;
        check("R5 load pin low blocks read", rd_data, last_out);
        idle(5);
        expect_flags("R5 no word consumed");
        @(negedge clk); wr_en2_ld = 1'b0; wr_en1_n = 1'b0; wr_data = 9'h111;
        @(negedge clk); wr_en2_ld = 1'b1; wr_en1_n = 1'b1;
        idle(5);
        expect_flags("R4 load pin low blocks write");
        pop("R7 first of pair");
        pop("R7 second of pair");
        idle(5);
        expect_flags("R4 no stray word stored");

        // two-write-enable mode: offsets ignored
        empty_ofs = 6'd20; full_ofs = 6'd30;
        do_reset(1'b1);
        check("R3 load_mode after high pin in reset", load_mode, 0);
        expect_flags("R1 reset flags dual mode");
        @(negedge clk); wr_en2_ld = 1'b0; wr_en1_n = 1'b0; wr_data = 9'h0F0;
        @(negedge clk); wr_en2_ld = 1'b1; wr_en1_n = 1'b1;
        idle(5);
        expect_flags("R4 second enable low blocks write");
        for (int k = 1; k <= DEPTH; k++) begin
            val = 9'(k * 53 + 9);
            push(val);
            model.push_back(int'(val));
            idle(5);
            expect_flags("R3 default offsets 7 fill");
        end
        @(negedge clk); wr_en2_ld = 1'b0; rd_en1_n = 1'b0; rd_en2_n = 1'b0;
        @(negedge clk); wr_en2_ld = 1'b1; rd_en1_n = 1'b1; rd_en2_n = 1'b1;
        last_out = 9'(model.pop_front());
        check("R5 pin does not gate reads in dual mode", rd_data, last_out);
        for (int k = 0; k < 10; k++) begin
            pop("R7 dual mode order");
            idle(5);
            expect_flags("R3 default offsets 7 drain");
        end

        // reset with words stored, boundary offsets 0 and DEPTH-1
        empty_ofs = 6'd0; full_ofs = 6'd0;
        do_reset(1'b0);
        expect_flags("R1 mid-run reset flags");
        check("R1 mid-run reset clears rd_data", rd_data, 0);
        sweep("n=0 m=0");
        empty_ofs = 6'd63; full_ofs = 6'd63;
        n_cur = 63; m_cur = 63;
        idle(5);
        sweep("n=63 m=63");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule